// File: doc/BRIEF.md
# Sleep-Mode Clock Gating Controller

This block sits beside a small microcontroller core. It decides which clock domains and which oscillator keep running while the core sleeps. A sleep request is taken when the sleep-enable input is high on the same clock as the sleep strobe. The 3-bit mode select is then latched, and the block gates the CPU, flash, I/O, ADC and asynchronous-timer clock enables and the main oscillator enable to suit that mode.

While asleep, each incoming wake flag passes through a mask that depends on the mode. The deeper the mode, the fewer sources can end sleep. Edge-type external interrupts count only in the lightest mode. After an accepted wake event there are two phases. If the mode stopped the main oscillator, the oscillator is switched back on and a programmable start-up count runs first. A fixed four-cycle CPU hold always follows. The block then issues a one-cycle resume pulse. A reset event while the block is out of the active state ends sleep at once and raises a reset-vector request instead of the resume pulse.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: A sleep strobe with sleep_en low is ignored: all clock enables stay high, no adc_start pulse occurs, and no later wake sequence follows.
- R2: Mode 000 (Idle) gates off only the CPU and flash enables. The I/O, ADC and async enables and osc_en stay high. Every wake source, edge or level, ends sleep.
- R3: Mode 001 (ADC noise reduction) gates off CPU, flash and I/O and keeps ADC, async and osc_en on. Wake sources are adc_done, twi_match, tmr2_evt, nvm_rdy and level-type external interrupts. io_irq is not a wake source.
- R4: Mode 010 (Power-down) clears every clock enable and osc_en. Wake sources are twi_match and level-type external interrupts.
- R5: Mode 011 (Power-save) acts as Power-down, except when async_tmr_en is 1. In that case clk_en_async stays high and tmr2_evt also wakes.
- R6: Mode 110 (Standby) acts as Power-down, except that osc_en stays high and no start-up count is applied.
- R7: Modes 100, 101 and 111 behave exactly as Idle.
- R8: An external interrupt whose type input is 0 (edge) does not wake the core in any mode other than Idle. A type input of 1 marks it as level type.
- R9: Entering Idle, a mode treated as Idle, or ADC noise reduction with adc_en high gives exactly one adc_start pulse, in the first sleep cycle. No other mode produces it.
- R10: The clock edge that samples an accepted wake is followed by the resume sequence. In Power-down or Power-save with startup_cnt N>0, cpu_resume is high after exactly N+4 further edges. In all other cases it is high after 4. The pulse lasts one cycle, and the CPU enable is high from that cycle on.
- R11: sys_reset high in any non-active state returns the block to active on the next edge. reset_vec_req then pulses for one cycle, and cpu_resume is not raised for that sleep.
- R12: After rst_n, all clock enables and osc_en are high and all three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| sleep_en | input | 1 | Sleep permitted |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| mode_sel | input | 3 | Sleep mode select |
| async_tmr_en | input | 1 | Timer 2 runs from its own asynchronous clock |
| adc_en | input | 1 | ADC is enabled |
| startup_cnt | input | SU_W | Oscillator start-up cycles |
| ext0_req | input | 1 | External interrupt 0 pending |
| ext0_level | input | 1 | External interrupt 0 is level type (1) or edge type (0) |
| ext1_req | input | 1 | External interrupt 1 pending |
| ext1_level | input | 1 | External interrupt 1 is level type (1) or edge type (0) |
| twi_match | input | 1 | Two-wire address match |
| tmr2_evt | input | 1 | Timer 2 interrupt |
| nvm_rdy | input | 1 | Program/EEPROM memory ready |
| adc_done | input | 1 | ADC conversion complete |
| io_irq | input | 1 | Any other I/O interrupt |
| sys_reset | input | 1 | Reset event (external, watchdog, brown-out) |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | One-cycle ADC conversion start |
| cpu_resume | output | 1 | One-cycle CPU resume |
| reset_vec_req | output | 1 | One-cycle reset-vector request |

## Verification
The bench builds the block with SU_W = 4, so startup_cnt covers its whole range from 0 to 15. Random draws therefore reach both the zero-count shortcut and the largest start-up delay in every mode that stops the oscillator. All eight mode codes, the async-timer and ADC-enable settings, and single wake sources of both interrupt types are drawn at random. Directed cases cover the ignored strobe, a rejected edge interrupt in Power-down, and a reset that arrives during the start-up count.

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl #(
  parameter int SU_W = 16,
  parameter int HALT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_en,
  input  logic            sleep_strobe,
  input  logic [2:0]      mode_sel,
  input  logic            async_tmr_en,
  input  logic            adc_en,
  input  logic [SU_W-1:0] startup_cnt,
  input  logic            ext0_req,
  input  logic            ext0_level,
  input  logic            ext1_req,
  input  logic            ext1_level,
  input  logic            twi_match,
  input  logic            tmr2_evt,
  input  logic            nvm_rdy,
  input  logic            adc_done,
  input  logic            io_irq,
  input  logic            sys_reset,
  output logic            clk_en_cpu,
  output logic            clk_en_flash,
  output logic            clk_en_io,
  output logic            clk_en_adc,
  output logic            clk_en_async,
  output logic            osc_en,
  output logic            adc_start,
  output logic            cpu_resume,
  output logic            reset_vec_req
);
  localparam int HW = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1;

  typedef enum logic [1:0] {ST_ACTIVE, ST_SLEEP, ST_STARTUP, ST_HALT4} st_t;

  st_t             st;
  logic [2:0]      m;
  logic [SU_W-1:0] cnt;
  logic [HW-1:0]   hcnt;

  logic m_adc, m_pd, m_ps, m_sb, m_idle, osc_stops;
  assign m_adc  = (m == 3'b001);
  assign m_pd   = (m == 3'b010);
  assign m_ps   = (m == 3'b011);
  assign m_sb   = (m == 3'b110);
  assign m_idle = !(m_adc || m_pd || m_ps || m_sb);
  assign osc_stops = m_pd || m_ps;

  logic new_conv;
  assign new_conv = adc_en && !(mode_sel inside {3'b010, 3'b011, 3'b110});

  logic lvl_int, any_int, wake_ok;
  assign lvl_int = (ext0_req && ext0_level) || (ext1_req && ext1_level);
  assign any_int = ext0_req || ext1_req || twi_match || tmr2_evt || nvm_rdy
                   || adc_done || io_irq;
  assign wake_ok = m_idle ? any_int :
                   m_adc  ? (lvl_int || twi_match || tmr2_evt || nvm_rdy || adc_done) :
                   m_ps   ? (lvl_int || twi_match || (tmr2_evt && async_tmr_en)) :
                            (lvl_int || twi_match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_ACTIVE;
      m             <= 3'b000;
      cnt           <= '0;
      hcnt          <= '0;
      adc_start     <= 1'b0;
      cpu_resume    <= 1'b0;
      reset_vec_req <= 1'b0;
    end else begin
      adc_start     <= 1'b0;
      cpu_resume    <= 1'b0;
      reset_vec_req <= 1'b0;
      if (st == ST_ACTIVE) begin
        if (sleep_strobe && sleep_en) begin
          st        <= ST_SLEEP;
          m         <= mode_sel;
          adc_start <= new_conv;
        end
      end else if (sys_reset) begin
        st            <= ST_ACTIVE;
        reset_vec_req <= 1'b1;
      end else begin
        case (st)
          ST_SLEEP: if (wake_ok) begin
            if (osc_stops && startup_cnt != '0) begin
              st  <= ST_STARTUP;
              cnt <= startup_cnt;
            end else begin
              st   <= ST_HALT4;
              hcnt <= HW'(HALT_CYC - 1);
            end
          end
          ST_STARTUP: begin
            if (cnt == SU_W'(1)) begin
              st   <= ST_HALT4;
              hcnt <= HW'(HALT_CYC - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_HALT4: begin
            if (hcnt == '0) begin
              st         <= ST_ACTIVE;
              cpu_resume <= 1'b1;
            end else begin
              hcnt <= hcnt - 1'b1;
            end
          end
          default: st <= ST_ACTIVE;
        endcase
      end
    end
  end

  logic in_act, in_h4, in_slp, asleep;
  assign in_act = (st == ST_ACTIVE);
  assign in_h4  = (st == ST_HALT4);
  assign in_slp = (st == ST_SLEEP);
  assign asleep = in_slp || (st == ST_STARTUP);

  assign clk_en_cpu   = in_act;
  assign clk_en_flash = in_act;
  assign clk_en_io    = in_act || in_h4 || (in_slp && m_idle);
  assign clk_en_adc   = in_act || in_h4 || (in_slp && (m_idle || m_adc));
  assign clk_en_async = in_act || in_h4 ||
                        (asleep && (m_idle || m_adc || (m_ps && async_tmr_en)));
  assign osc_en       = !(in_slp && osc_stops);

  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_resume && reset_vec_req));

  assert_resume_after_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT4 && hcnt == '0 && !sys_reset) |=> (cpu_resume && clk_en_cpu));

  assert_adc_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_act && sleep_strobe && sleep_en && new_conv) |=> adc_start);

  assert_strobe_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_act && sleep_strobe && !sleep_en) |=> (clk_en_cpu && !adc_start));

  assert_reset_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_act && sys_reset) |=> (reset_vec_req && in_act && !cpu_resume));

  assert_startup_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STARTUP) |-> (osc_en && !clk_en_cpu));
endmodule

// File: tb/test_sleep_clk_ctrl.sv
module test_sleep_clk_ctrl;
  localparam int SU_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_en = 0, sleep_strobe = 0, async_tmr_en = 0, adc_en = 0;
  logic [2:0] mode_sel = 0;
  logic [SU_W-1:0] startup_cnt = 0;
  logic ext0_req = 0, ext0_level = 0, ext1_req = 0, ext1_level = 0;
  logic twi_match = 0, tmr2_evt = 0, nvm_rdy = 0, adc_done = 0, io_irq = 0, sys_reset = 0;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en;
  logic adc_start, cpu_resume, reset_vec_req;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sleep_clk_ctrl #(.SU_W(SU_W)) i_sleep_clk_ctrl (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int md);
    return (md inside {1, 2, 3, 6}) ? md : 0;
  endfunction

  function automatic string tag(input int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // {cpu, flash, io, adc, async, osc}
  function automatic logic [5:0] exp_en(input int md, input bit as);
    case (eff(md))
      0: return 6'b001111;
      1: return 6'b000111;
      2: return 6'b000000;
      3: return {4'b0000, as, 1'b0};
      default: return 6'b000001;
    endcase
  endfunction

  // sources: 0 ext0, 1 ext1, 2 twi, 3 tmr2, 4 nvm, 5 adc, 6 io
  function automatic bit wake_ok(input int md, input int src, input bit lvl, input bit as);
    int e = eff(md);
    if (e == 0) return 1;
    if (src <= 1) return lvl;
    if (src == 2) return 1;
    if (e == 1) return src inside {3, 4, 5};
    if (e == 3) return (src == 3) && as;
    return 0;
  endfunction

  function automatic logic [5:0] cur_en();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en};
  endfunction

  task automatic clr_src();
    ext0_req = 0; ext1_req = 0; twi_match = 0; tmr2_evt = 0;
    nvm_rdy = 0; adc_done = 0; io_irq = 0;
  endtask

  task automatic set_src(input int src, input bit lvl);
    case (src)
      0: begin ext0_req = 1; ext0_level = lvl; end
      1: begin ext1_req = 1; ext1_level = lvl; end
      2: twi_match = 1;
      3: tmr2_evt = 1;
      4: nvm_rdy = 1;
      5: adc_done = 1;
      default: io_irq = 1;
    endcase
  endtask

  // called at a negedge; returns with the block in SLEEP, at a negedge
  task automatic enter(input int md, input bit adc, input bit as, input int su);
    mode_sel = 3'(md); adc_en = adc; async_tmr_en = as; startup_cnt = SU_W'(su);
    sleep_en = 1; sleep_strobe = 1;
    @(posedge clk); @(negedge clk);
    sleep_strobe = 0; sleep_en = 0;
    check(cur_en() == exp_en(md, as), tag(md), cur_en(), exp_en(md, as));
    check(adc_start == (adc && eff(md) <= 1), "R9", adc_start, adc && eff(md) <= 1);
  endtask

  // drive source at negedge, count edges until cpu_resume
  task automatic wake_measure(input int src, input bit lvl, input int exp_n);
    int n = 0;
    set_src(src, lvl);
    @(posedge clk);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      clr_src();
      if (cpu_resume) break;
      @(posedge clk);
      n++;
    end
    check(cpu_resume && n == exp_n, "R10", n, exp_n);
    @(negedge clk);
    check(!cpu_resume && clk_en_cpu, "R10", {cpu_resume, clk_en_cpu}, 1);
  endtask

  initial begin
    process::self().srandom(32'd7345);
    repeat (2) @(negedge clk);
    check(cur_en() == 6'b111111 && !adc_start && !cpu_resume && !reset_vec_req,
          "R12", cur_en(), 6'b111111);
    rst_n = 1;
    @(negedge clk);

    // R1: strobe without enable
    mode_sel = 3'd2; adc_en = 1; sleep_en = 0; sleep_strobe = 1;
    @(posedge clk); @(negedge clk);
    sleep_strobe = 0;
    check(cur_en() == 6'b111111 && !adc_start, "R1", cur_en(), 6'b111111);
    twi_match = 1;
    repeat (6) begin
      @(posedge clk); @(negedge clk);
      check(!cpu_resume && clk_en_cpu, "R1", cpu_resume, 0);
    end
    twi_match = 0;

    // R8: edge-type interrupt ignored in Power-down
    enter(2, 0, 0, 3);
    ext0_req = 1; ext0_level = 0; ext1_req = 1; ext1_level = 0;
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      check(!clk_en_cpu && !cpu_resume && !osc_en, "R8", cur_en(), 0);
    end
    clr_src();
    wake_measure(0, 1, 3 + 4);

    // R11: reset during start-up count
    enter(3, 0, 1, 15);
    twi_match = 1;
    @(posedge clk); @(negedge clk);
    twi_match = 0;
    check(osc_en && !clk_en_cpu, "R10", osc_en, 1);
    sys_reset = 1;
    @(posedge clk); @(negedge clk);
    sys_reset = 0;
    check(reset_vec_req && !cpu_resume && clk_en_cpu, "R11",
          {reset_vec_req, cpu_resume, clk_en_cpu}, 3'b101);
    @(negedge clk);
    check(!reset_vec_req && !cpu_resume, "R11", reset_vec_req, 0);

    // R11: reset in Idle sleep
    enter(0, 1, 0, 2);
    sys_reset = 1;
    @(posedge clk); @(negedge clk);
    sys_reset = 0;
    check(reset_vec_req && clk_en_cpu, "R11", reset_vec_req, 1);

    // R6: Standby with large count ignores it
    enter(6, 1, 0, 15);
    wake_measure(1, 1, 4);

    // R4: Power-down, zero count
    enter(2, 0, 0, 0);
    wake_measure(2, 0, 4);

    // R10: maximum count
    enter(2, 0, 0, 15);
    wake_measure(2, 0, 19);

    for (int it = 0; it < 120; it++) begin
      int md  = $urandom_range(0, 7);
      bit adc = 1'($urandom_range(0, 1));
      bit as  = 1'($urandom_range(0, 1));
      int su  = $urandom_range(0, 15);
      int src = $urandom_range(0, 6);
      bit lvl = 1'($urandom_range(0, 1));
      int e   = eff(md);
      int exp_n = ((e == 2 || e == 3) && su != 0) ? su + 4 : 4;
      enter(md, adc, as, su);
      if (wake_ok(md, src, lvl, as)) begin
        wake_measure(src, lvl, exp_n);
      end else begin
        set_src(src, lvl);
        repeat (3) begin
          @(posedge clk); @(negedge clk);
          check(!clk_en_cpu && !cpu_resume && cur_en() == exp_en(md, as),
                (src <= 1) ? "R8" : tag(md), cur_en(), exp_en(md, as));
        end
        clr_src();
        wake_measure(2, 0, exp_n);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule